// File: doc/BRIEF.md
# Sleep-Mode Tracker with Low-Power Pad and Warm-Restart Sequencer

This block tracks the power state of the chip (awake, low-power, deep sleep) and raises a low-power indicator whenever the chip is not awake. A software-written select picks what drives a shared pad: either that indicator or a general-purpose data bit. In deep sleep the main oscillator enable is dropped. A warm-restart event clears any sleep state and brings the indicator low. It then switches the oscillator enable back on and counts down a programmable settle delay on an always-on slow tick. After that it gives the processor a single-cycle reboot-release pulse and returns to awake.

Sleep entry is requested by a one-cycle pulse together with a mode bit. Leaving low-power mode without a restart uses a separate wake pulse. Deep sleep is left only through a warm restart. The pad select is cleared only by the block reset and survives warm restarts. All outputs are registered and change on the clock edge that samples the causing input.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After `rst`, the block is awake: `osc_en`=1, `reboot_go`=0, the pad select is 0 (pad driven by `gpio_out`) and `pad_out`=0.
- R2: In the awake state, `sleep_req`=1 with `sleep_deep`=0 enters low-power: the indicator goes to 1 and `osc_en` stays 1, on the edge that samples the request.
- R3: In the awake state, `sleep_req`=1 with `sleep_deep`=1 enters deep sleep: the indicator goes to 1 and `osc_en` goes to 0 on that edge, and `osc_en` stays 0 throughout deep sleep.
- R4: `wake_req`=1 in low-power returns to awake (indicator 0). `wake_req` has no effect in deep sleep.
- R5: `pad_out` is registered. Select 1 drives the indicator onto the pad and select 0 drives `gpio_out` onto it. A write with `sel_wr`=1 loads `sel_din` into the select.
- R6: A warm restart (`warm_rst`=1) never changes the pad select.
- R7: A warm restart in the awake state keeps the indicator at 0. In low-power or deep sleep, it drops the indicator to 0 on the sampling edge. In all three states it starts the settle phase.
- R8: A warm restart in deep sleep sets `osc_en` to 1 on the sampling edge.
- R9: On entry to the settle phase, a down-counter loads `settle_dly`. Each cycle with `slow_tick`=1 lowers it by one. `reboot_go` rises one cycle after the counter reads zero, so a delay of 0 releases on the cycle after entry, and a delay of D with a tick every cycle releases D+1 cycles after entry.
- R10: `reboot_go` is high for exactly one cycle, after which the block is awake and accepts a new sleep request.
- R11: During the settle phase and the release cycle, `sleep_req`, `wake_req` and `warm_rst` have no effect. When `warm_rst` and `sleep_req` arrive together, the warm restart wins.
- R12: `sleep_req` in low-power or deep sleep causes no mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset, clears everything including the pad select |
| slow_tick | input | 1 | Always-on slow clock enable for the settle counter |
| sleep_req | input | 1 | One-cycle sleep request |
| sleep_deep | input | 1 | Sleep kind: 1 deep sleep, 0 low-power |
| wake_req | input | 1 | One-cycle request to leave low-power |
| warm_rst | input | 1 | Warm-restart event |
| sel_wr | input | 1 | Pad-select write strobe |
| sel_din | input | 1 | Pad-select value: 1 indicator, 0 general-purpose bit |
| gpio_out | input | 1 | General-purpose data bit for the pad |
| settle_dly | input | DLY_W | Oscillator settle delay in slow ticks |
| osc_en | output | 1 | Main oscillator enable |
| pad_out | output | 1 | Shared pad output |
| reboot_go | output | 1 | One-cycle reboot release to the processor |

## Verification
Mode changes, oscillator enable and pad value are all due one cycle after the inputs are driven. The reboot pulse is due a number of cycles that depends on the delay and the slow ticks seen, which is D+1 cycles after the restart edge when a tick comes every cycle. The bench drives inputs just after a falling edge. A cycle-level expectation model advances on the same rising edge as the design, and every output is compared at the following falling edge. Directed sequences check exact cycle counts with literal expected values, and a seeded random phase covers the timing of requests that overlap.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [2:0] {
    PS_AWAKE  = 3'd0,
    PS_LOWPWR = 3'd1,
    PS_DEEP   = 3'd2,
    PS_SETTLE = 3'd3,
    PS_REBOOT = 3'd4
  } pwr_state_e;

  function automatic logic ind_of(input pwr_state_e s);
    return (s == PS_LOWPWR) || (s == PS_DEEP);
  endfunction
endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  output logic             done
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                              cnt_q <= '0;
    else if (load)                        cnt_q <= dly;
    else if (run && tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R9: one step down per tick while counting
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R9: no tick, no change
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       sleep_deep,
  input  logic       wake_req,
  input  logic       warm_rst,
  input  logic       settle_done,
  output pwr_state_e state_q,
  output logic       ind_next,
  output logic       settle_load,
  output logic       settle_run,
  output logic       osc_en,
  output logic       reboot_go
);
  pwr_state_e state_d;

  always_comb begin
    state_d     = state_q;
    settle_load = 1'b0;
    unique case (state_q)
      PS_AWAKE: begin
        if (warm_rst) begin
          state_d = PS_SETTLE; settle_load = 1'b1;
        end else if (sleep_req) begin
          state_d = sleep_deep ? PS_DEEP : PS_LOWPWR;
        end
      end
      PS_LOWPWR: begin
        if (warm_rst) begin
          state_d = PS_SETTLE; settle_load = 1'b1;
        end else if (wake_req) begin
          state_d = PS_AWAKE;
        end
      end
      PS_DEEP: begin
        if (warm_rst) begin
          state_d = PS_SETTLE; settle_load = 1'b1;
        end
      end
      PS_SETTLE: if (settle_done) state_d = PS_REBOOT;
      PS_REBOOT: state_d = PS_AWAKE;
      default:   state_d = PS_AWAKE;
    endcase
  end

  assign ind_next   = ind_of(state_d);
  assign settle_run = (state_q == PS_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PS_AWAKE;
      osc_en    <= 1'b1;
      reboot_go <= 1'b0;
    end else begin
      state_q   <= state_d;
      osc_en    <= (state_d != PS_DEEP);
      reboot_go <= (state_d == PS_REBOOT);
    end
  end

  p_deep_osc_off_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_DEEP) |-> !osc_en);
  p_warm_osc_on_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_DEEP && warm_rst) |=> osc_en);
  p_warm_settle_r7: assert property (@(posedge clk) disable iff (rst)
    (warm_rst && (state_q == PS_AWAKE || state_q == PS_LOWPWR || state_q == PS_DEEP))
    |=> (state_q == PS_SETTLE));
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SETTLE && settle_done) |=> reboot_go);
  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    reboot_go |=> (!reboot_go && state_q == PS_AWAKE));
  p_deep_stays_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_DEEP && !warm_rst) |=> (state_q == PS_DEEP));
endmodule

// File: rtl/pwr_pad_mux.sv
module pwr_pad_mux (
  input  logic clk,
  input  logic rst,
  input  logic sel_wr,
  input  logic sel_din,
  input  logic gpio_out,
  input  logic ind_next,
  output logic sel_q,
  output logic pad_out
);
  logic sel_d;

  assign sel_d = sel_wr ? sel_din : sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      pad_out <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      pad_out <= sel_d ? ind_next : gpio_out;
    end
  end

  p_pad_gpio_r5: assert property (@(posedge clk) disable iff (rst)
    (!sel_wr && !sel_q) |=> (pad_out == $past(gpio_out)));
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_tick,
  input  logic             sleep_req,
  input  logic             sleep_deep,
  input  logic             wake_req,
  input  logic             warm_rst,
  input  logic             sel_wr,
  input  logic             sel_din,
  input  logic             gpio_out,
  input  logic [DLY_W-1:0] settle_dly,
  output logic             osc_en,
  output logic             pad_out,
  output logic             reboot_go
);
  pwr_state_e state_q;
  logic       ind_next, settle_load, settle_run, settle_done, sel_q;

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
    .wake_req(wake_req), .warm_rst(warm_rst), .settle_done(settle_done),
    .state_q(state_q), .ind_next(ind_next), .settle_load(settle_load),
    .settle_run(settle_run), .osc_en(osc_en), .reboot_go(reboot_go)
  );

  pwr_settle_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .load(settle_load), .run(settle_run),
    .tick(slow_tick), .dly(settle_dly), .done(settle_done)
  );

  pwr_pad_mux u_pad (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_din(sel_din),
    .gpio_out(gpio_out), .ind_next(ind_next), .sel_q(sel_q), .pad_out(pad_out)
  );

  p_sel_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (warm_rst && !sel_wr) |=> $stable(sel_q));
  p_settle_ind_low_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SETTLE && sel_q) |-> !pad_out);
endmodule

// File: tb/test_pwr_wake_ctrl.sv
module test_pwr_wake_ctrl;
  localparam int DLY_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic slow_tick = 0, sleep_req = 0, sleep_deep = 0, wake_req = 0, warm_rst = 0;
  logic sel_wr = 0, sel_din = 0, gpio_out = 0;
  logic [DLY_W-1:0] settle_dly = '0;
  logic osc_en, pad_out, reboot_go;
  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  always #10 clk = ~clk;

  pwr_wake_ctrl #(.DLY_W(DLY_W)) i_pwr_wake_ctrl (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .sleep_req(sleep_req),
    .sleep_deep(sleep_deep), .wake_req(wake_req), .warm_rst(warm_rst),
    .sel_wr(sel_wr), .sel_din(sel_din), .gpio_out(gpio_out),
    .settle_dly(settle_dly), .osc_en(osc_en), .pad_out(pad_out), .reboot_go(reboot_go)
  );

  // expectation model: 0 awake, 1 low-power, 2 deep, 3 settle, 4 release
  int m_st = 0, m_cnt = 0;
  logic m_sel = 0, e_osc = 1, e_pad = 0, e_rb = 0;

  always @(posedge clk) begin
    int nx, nc;
    logic ns;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_sel = 0; e_osc = 1; e_pad = 0; e_rb = 0;
    end else begin
      nx = m_st; nc = m_cnt;
      case (m_st)
        0: if (warm_rst) begin nx = 3; nc = settle_dly; end
           else if (sleep_req) nx = sleep_deep ? 2 : 1;
        1: if (warm_rst) begin nx = 3; nc = settle_dly; end
           else if (wake_req) nx = 0;
        2: if (warm_rst) begin nx = 3; nc = settle_dly; end
        3: if (m_cnt == 0) nx = 4;
           else if (slow_tick) nc = m_cnt - 1;
        default: nx = 0;
      endcase
      ns = sel_wr ? sel_din : m_sel;
      e_osc = (nx != 2);
      e_rb  = (nx == 4);
      e_pad = ns ? (nx == 1 || nx == 2) : gpio_out;
      m_st = nx; m_cnt = nc; m_sel = ns;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk("R8 osc_en model", osc_en, e_osc);
    chk("R5 pad_out model", pad_out, e_pad);
    chk("R9 reboot_go model", reboot_go, e_rb);
  endtask

  task automatic idle();
    sleep_req = 0; wake_req = 0; warm_rst = 0; sel_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 osc_en after reset", osc_en, 1'b1);
    chk("R1 pad_out after reset", pad_out, 1'b0);
    chk("R1 reboot_go after reset", reboot_go, 1'b0);
    gpio_out = 1; cyc();
    chk("R1 select defaults to gpio", pad_out, 1'b1);
    gpio_out = 0;

    // select indicator
    sel_wr = 1; sel_din = 1; cyc(); idle();
    chk("R5 indicator on pad while awake", pad_out, 1'b0);
    // low-power entry / exit
    sleep_req = 1; sleep_deep = 0; cyc(); idle();
    chk("R2 indicator high in low-power", pad_out, 1'b1);
    chk("R2 osc kept on", osc_en, 1'b1);
    sleep_req = 1; sleep_deep = 1; cyc(); idle();
    chk("R12 sleep in low-power ignored", osc_en, 1'b1);
    wake_req = 1; cyc(); idle();
    chk("R4 wake leaves low-power", pad_out, 1'b0);
    // deep sleep
    sleep_req = 1; sleep_deep = 1; cyc(); idle();
    chk("R3 osc off in deep", osc_en, 1'b0);
    chk("R3 indicator high in deep", pad_out, 1'b1);
    wake_req = 1; cyc(); idle();
    chk("R4 wake ignored in deep", osc_en, 1'b0);
    chk("R4 indicator kept in deep", pad_out, 1'b1);
    // warm restart from deep, zero delay
    settle_dly = 0; slow_tick = 0;
    warm_rst = 1; cyc(); idle();
    chk("R8 osc back on", osc_en, 1'b1);
    chk("R7 indicator dropped", pad_out, 1'b0);
    chk("R9 no release yet", reboot_go, 1'b0);
    cyc();
    chk("R9 zero delay releases next cycle", reboot_go, 1'b1);
    cyc();
    chk("R10 pulse one cycle", reboot_go, 1'b0);
    sleep_req = 1; sleep_deep = 0; cyc(); idle();
    chk("R6 select survived warm restart", pad_out, 1'b1);
    wake_req = 1; cyc(); idle();
    // warm restart while awake, delay 3, tick every cycle
    settle_dly = 3; slow_tick = 1;
    warm_rst = 1; cyc(); idle();
    chk("R7 indicator stays low when awake", pad_out, 1'b0);
    sleep_req = 1; sleep_deep = 1; warm_rst = 1;
    for (int k = 1; k <= 3; k++) begin
      cyc();
      chk("R9 still settling", reboot_go, 1'b0);
      chk("R11 sleep ignored in settle", osc_en, 1'b1);
    end
    cyc();
    chk("R9 release after D+1 cycles", reboot_go, 1'b1);
    cyc(); warm_rst = 0;
    chk("R10 pulse ends", reboot_go, 1'b0);
    chk("R11 sleep ignored in release", osc_en, 1'b1);
    cyc(); idle();
    chk("R10 sleep accepted after release", osc_en, 1'b0);
    // warm beats sleep while awake
    settle_dly = 0; warm_rst = 1; cyc(); idle();
    cyc(); cyc();
    warm_rst = 1; sleep_req = 1; sleep_deep = 1; cyc(); idle();
    chk("R11 warm wins over sleep", osc_en, 1'b1);
    chk("R11 warm wins indicator", pad_out, 1'b0);
    cyc(); cyc();
    // gpio path
    sel_wr = 1; sel_din = 0; gpio_out = 1; cyc(); idle();
    chk("R5 gpio on pad", pad_out, 1'b1);
    gpio_out = 0; cyc();
    chk("R5 gpio follows", pad_out, 1'b0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      slow_tick  = ($urandom % 3) == 0;
      sleep_req  = ($urandom % 14) == 0;
      sleep_deep = $urandom % 2;
      wake_req   = ($urandom % 10) == 0;
      warm_rst   = ($urandom % 45) == 0;
      sel_wr     = ($urandom % 25) == 0;
      sel_din    = $urandom % 2;
      gpio_out   = $urandom % 2;
      settle_dly = DLY_W'($urandom % 6);
      cyc();
    end

    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule